// File: doc/BRIEF.md
# JPEG Segment Parser with Error Hold

The block sits at the front of a baseline image decoder. It takes the compressed byte stream as 32-bit words, each word qualified by a thermometer-coded byte-valid field and accepted under an acknowledge. It walks the marker structure of one image at a time: it hunts for the start-of-image marker, then reads header segments in whatever order they come. Segments that downstream logic needs go out byte by byte on a header port, each byte tagged with its segment's marker code. Application and comment segments are stepped over by their length field and dropped.

Once the start-of-scan header has been forwarded, the block passes entropy-coded bytes out on a scan port. It collapses stuffed `FF 00` pairs into a single `FF` byte and turns restart markers into one-cycle events. It signals the end-of-image marker as a one-cycle pulse and then returns to hunting.

Any structural fault stops the block. An error code is latched and acknowledge is held low until the clear input has been seen high and then low. The block then discards input until the next start-of-image marker.

Top module: `jseg_parser`

## Requirements
- R1: A word is taken only in a cycle where `in_bvalid` is non-zero and `in_ack` is high. Its bytes are used lowest lane first (`in_data[7:0]` first). A last word may carry 1 to 3 bytes, contiguous from lane 0. `in_ack` is low whenever `err_code` is non-zero.
- R2: Before a start-of-image marker (`FF D8`), every byte is discarded and no output fires, whatever marker-like bytes it contains.
- R3: The segments with codes C0, C4, DB, DD and DA are accepted in any order. Each carries a two-byte big-endian length that counts itself. The body bytes (length minus 2 of them) appear on `hdr_data` with `hdr_valid`. `hdr_tag` holds the marker code, and `hdr_first` is high on the first body byte only.
- R4: Segments with codes E0 to EF and FE are skipped by their length field and produce no output.
- R5: Extra `FF` fill bytes before a marker code are ignored, both in headers and in scan data.
- R6: After the DA segment body, scan bytes appear one per `scan_valid` pulse. The pair `FF 00` yields a single `FF` data byte.
- R7: In scan data, `FF D0` to `FF D7` give a one-cycle `scan_restart` with `scan_rst_num` equal to the low three bits of the code. Restart numbering and the DD segment contents are never checked against each other and raise no error.
- R8: `FF D9` in scan data gives a one-cycle `img_end`, and the block returns to hunting for start-of-image.
- R9: `err_code` is 0 when there is no error. Code 1 (invalid) is raised for marker codes 00 to BF. Code 2 (unsupported) is raised for C1 to CF other than C4, and for DC, DE, DF and F0 to FD.
- R10: Code 3 (unexpected) is raised for D8, D9 or D0 to D7 in the header region, including end-of-image before start-of-scan. It is also raised for any other valid code that appears in scan data apart from a restart or end-of-image marker.
- R11: `scan_err` high while the block is in scan data raises code 4. Outside scan data it has no effect.
- R12: A segment length below 2, or a non-`FF` byte where a marker is due in the header region, raises code 7.
- R13: While in error, no output fires and the code holds while `clr_err` is high. After `clr_err` has been high and then low, `err_code` returns to 0 and input is discarded until the next start-of-image.
- R14: `rst_n` is an active-low asynchronous reset. It clears `err_code` and all outputs and leaves the block hunting, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 32 | Stream word, lane 0 in bits 7:0 |
| in_bvalid | input | 4 | Thermometer byte-valid field |
| in_ack | output | 1 | Word accepted at this edge when valid is non-zero |
| scan_err | input | 1 | Downstream scan decode fault |
| clr_err | input | 1 | Error clear, acts on its high-then-low sequence |
| hdr_valid | output | 1 | Header body byte strobe |
| hdr_data | output | 8 | Header body byte |
| hdr_tag | output | 8 | Marker code of the segment being forwarded |
| hdr_first | output | 1 | First body byte of a segment |
| scan_valid | output | 1 | Scan data byte strobe |
| scan_data | output | 8 | Unstuffed scan byte |
| scan_restart | output | 1 | Restart marker event |
| scan_rst_num | output | 3 | Restart marker number |
| img_end | output | 1 | End-of-image pulse |
| err_code | output | 3 | Latched error category |

## Verification
A word is taken at the edge where `in_ack` and a non-zero valid meet. Its lane-0 byte has its output registered one edge later, and each further lane follows one edge after the lane before it. An error code appears at the same edge that consumes the offending byte, or at the edge that samples `scan_err`. The error clears at the first edge that samples `clr_err` low after it was seen high. The scoreboard compares output events in order at falling edges, so the exact lane position of a byte never matters. Error codes, acknowledge and the empty-queue checks are sampled only after an idle drain of several cycles, and the clear sequence is checked one falling edge after each step.

// File: rtl/jsp_pkg.sv
// Shared types for the segment parser: error categories, marker classes
// and the byte-level walk states. Assumes 8-bit bytes and 16-bit lengths.
package jsp_pkg;

    localparam int LEN_W = 16;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_INVALID  = 3'd1,
        ERR_UNSUP    = 3'd2,
        ERR_UNEXP    = 3'd3,
        ERR_SCAN     = 3'd4,
        ERR_INTERNAL = 3'd7
    } err_e;

    typedef enum logic [2:0] {
        MC_INVALID,
        MC_UNSUP,
        MC_FWD,
        MC_SKIP,
        MC_SOS,
        MC_SOI,
        MC_EOI,
        MC_RST
    } mclass_e;

    typedef enum logic [3:0] {
        S_HUNT,
        S_HUNT_FF,
        S_MARK,
        S_CODE,
        S_LEN_HI,
        S_LEN_LO,
        S_BODY,
        S_SCAN,
        S_SCAN_FF,
        S_ERR
    } walk_e;

endpackage

// File: rtl/jsp_unpack.sv
// Word-to-byte serializer. Holds one accepted word and presents its valid
// bytes one per cycle, lane 0 first. Assumes the byte-valid field is a
// thermometer code. Acknowledge overlaps the last byte of the held word.
// A flush empties the buffer and blocks acknowledge.
module jsp_unpack #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [LANES*8-1:0] in_data,
    input  logic [LANES-1:0]   in_bvalid,
    output logic               in_ack,
    output logic               byte_vld,
    output logic [7:0]         byte_dat
);
    localparam int CNT_W = $clog2(LANES + 1);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES*8-1:0] word_q;
    logic [CNT_W-1:0]   cnt_q, idx_q, n_bytes;
    logic [7:0]         lanes [LANES];
    logic               busy, last, take;

    // Split the held word into lane bytes
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_q[g*8 +: 8];
    end

    // Count the valid lanes of the offered word
    always_comb begin
        n_bytes = '0;
        for (int i = 0; i < LANES; i++) n_bytes = n_bytes + CNT_W'(in_bvalid[i]);
    end

    assign busy     = (cnt_q != '0);
    assign last     = busy && ((idx_q + CNT_W'(1)) == cnt_q);
    assign in_ack   = !flush && (!busy || last);
    assign take     = in_ack && (in_bvalid != '0);
    assign byte_vld = busy && !flush;
    assign byte_dat = lanes[idx_q[IDX_W-1:0]];

    // Load, step through, or drop the held word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
        end else if (flush) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (take) begin
            word_q <= in_data;
            cnt_q  <= n_bytes;
            idx_q  <= '0;
        end else if (last) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (busy) begin
            idx_q <= idx_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/jsp_classify.sv
// Marker code classifier. Pure combinational map from the byte after an
// FF to its handling class. FF itself never reaches here as a code.
module jsp_classify
    import jsp_pkg::*;
(
    input  logic [7:0] code,
    output mclass_e    mclass
);
    // Map each code range to a class
    always_comb begin
        if (code < 8'hC0 || code == 8'hFF) begin
            mclass = MC_INVALID;
        end else begin
            unique casez (code)
                8'hC0, 8'hC4, 8'hDB, 8'hDD: mclass = MC_FWD;
                8'hDA:                      mclass = MC_SOS;
                8'hD8:                      mclass = MC_SOI;
                8'hD9:                      mclass = MC_EOI;
                8'b1101_0???:               mclass = MC_RST;
                8'b1110_????, 8'hFE:        mclass = MC_SKIP;
                default:                    mclass = MC_UNSUP;
            endcase
        end
    end

endmodule

// File: rtl/jsp_walk.sv
// Byte-level walk of the marker structure. Consumes one byte per valid
// cycle. It hunts for start-of-image, reads segment lengths, forwards or
// skips segment bodies, unstuffs scan data and latches errors. All outputs
// are registered at the edge that consumes the byte causing them.
module jsp_walk
    import jsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_dat,
    input  mclass_e    mclass,
    input  logic       scan_err,
    input  logic       clr_err,
    output logic       err_active,
    output logic [2:0] err_code,
    output logic       hdr_valid,
    output logic [7:0] hdr_data,
    output logic [7:0] hdr_tag,
    output logic       hdr_first,
    output logic       scan_valid,
    output logic [7:0] scan_data,
    output logic       scan_restart,
    output logic [2:0] scan_rst_num,
    output logic       img_end
);
    walk_e            st_q, st_n;
    err_e             err_q, err_n, err_sel;
    logic [LEN_W-1:0] len_q, len_n, len_full;
    logic [7:0]       tag_n, hdat_n, sdat_n;
    logic [2:0]       rnum_n;
    logic             fwd_q, fwd_n, sos_q, sos_n, first_q, first_n;
    logic             clr_q, clr_n, do_err;
    logic             hv_n, hf_n, sv_n, rs_n, end_n;
    logic             in_scan;

    assign in_scan  = (st_q == S_SCAN) || (st_q == S_SCAN_FF);
    assign len_full = {len_q[LEN_W-1:8], byte_dat};

    // Next-state and output decode for one consumed byte
    always_comb begin
        st_n    = st_q;
        err_n   = err_q;
        len_n   = len_q;
        fwd_n   = fwd_q;
        sos_n   = sos_q;
        first_n = first_q;
        clr_n   = clr_q;
        tag_n   = hdr_tag;
        hdat_n  = hdr_data;
        sdat_n  = scan_data;
        rnum_n  = scan_rst_num;
        hv_n    = 1'b0;
        hf_n    = 1'b0;
        sv_n    = 1'b0;
        rs_n    = 1'b0;
        end_n   = 1'b0;
        do_err  = 1'b0;
        err_sel = ERR_INTERNAL;
        if (st_q == S_ERR) begin
            if (clr_err) begin
                clr_n = 1'b1;
            end else if (clr_q) begin
                clr_n = 1'b0;
                err_n = ERR_NONE;
                st_n  = S_HUNT;
            end
        end else if (scan_err && in_scan) begin
            do_err  = 1'b1;
            err_sel = ERR_SCAN;
        end else if (byte_vld) begin
            unique case (st_q)
                S_HUNT: if (byte_dat == 8'hFF) st_n = S_HUNT_FF;
                S_HUNT_FF: begin
                    if (byte_dat == 8'hD8)      st_n = S_MARK;
                    else if (byte_dat != 8'hFF) st_n = S_HUNT;
                end
                S_MARK: begin
                    if (byte_dat == 8'hFF) st_n = S_CODE;
                    else begin
                        do_err  = 1'b1;
                        err_sel = ERR_INTERNAL;
                    end
                end
                S_CODE: begin
                    if (byte_dat != 8'hFF) begin
                        unique case (mclass)
                            MC_FWD, MC_SOS, MC_SKIP: begin
                                tag_n = byte_dat;
                                fwd_n = (mclass != MC_SKIP);
                                sos_n = (mclass == MC_SOS);
                                st_n  = S_LEN_HI;
                            end
                            MC_INVALID: begin
                                do_err  = 1'b1;
                                err_sel = ERR_INVALID;
                            end
                            MC_UNSUP: begin
                                do_err  = 1'b1;
                                err_sel = ERR_UNSUP;
                            end
                            default: begin
                                do_err  = 1'b1;
                                err_sel = ERR_UNEXP;
                            end
                        endcase
                    end
                end
                S_LEN_HI: begin
                    len_n = {byte_dat, 8'h00};
                    st_n  = S_LEN_LO;
                end
                S_LEN_LO: begin
                    if (len_full < LEN_W'(2)) begin
                        do_err  = 1'b1;
                        err_sel = ERR_INTERNAL;
                    end else if (len_full == LEN_W'(2)) begin
                        st_n = sos_q ? S_SCAN : S_MARK;
                    end else begin
                        len_n   = len_full - LEN_W'(2);
                        first_n = 1'b1;
                        st_n    = S_BODY;
                    end
                end
                S_BODY: begin
                    if (fwd_q) begin
                        hv_n   = 1'b1;
                        hf_n   = first_q;
                        hdat_n = byte_dat;
                    end
                    first_n = 1'b0;
                    len_n   = len_q - LEN_W'(1);
                    if (len_q == LEN_W'(1)) st_n = sos_q ? S_SCAN : S_MARK;
                end
                S_SCAN: begin
                    if (byte_dat == 8'hFF) st_n = S_SCAN_FF;
                    else begin
                        sv_n   = 1'b1;
                        sdat_n = byte_dat;
                    end
                end
                S_SCAN_FF: begin
                    if (byte_dat == 8'h00) begin
                        sv_n   = 1'b1;
                        sdat_n = 8'hFF;
                        st_n   = S_SCAN;
                    end else if (byte_dat != 8'hFF) begin
                        unique case (mclass)
                            MC_RST: begin
                                rs_n   = 1'b1;
                                rnum_n = byte_dat[2:0];
                                st_n   = S_SCAN;
                            end
                            MC_EOI: begin
                                end_n = 1'b1;
                                st_n  = S_HUNT;
                            end
                            MC_INVALID: begin
                                do_err  = 1'b1;
                                err_sel = ERR_INVALID;
                            end
                            MC_UNSUP: begin
                                do_err  = 1'b1;
                                err_sel = ERR_UNSUP;
                            end
                            default: begin
                                do_err  = 1'b1;
                                err_sel = ERR_UNEXP;
                            end
                        endcase
                    end
                end
                default: st_n = S_HUNT;
            endcase
        end
        if (do_err) begin
            err_n = err_sel;
            st_n  = S_ERR;
            clr_n = 1'b0;
            hv_n  = 1'b0;
            sv_n  = 1'b0;
            rs_n  = 1'b0;
            end_n = 1'b0;
        end
    end

    // Register walk state, error latch and output strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= S_HUNT;
            err_q        <= ERR_NONE;
            len_q        <= '0;
            fwd_q        <= 1'b0;
            sos_q        <= 1'b0;
            first_q      <= 1'b0;
            clr_q        <= 1'b0;
            hdr_valid    <= 1'b0;
            hdr_first    <= 1'b0;
            hdr_data     <= '0;
            hdr_tag      <= '0;
            scan_valid   <= 1'b0;
            scan_data    <= '0;
            scan_restart <= 1'b0;
            scan_rst_num <= '0;
            img_end      <= 1'b0;
        end else begin
            st_q         <= st_n;
            err_q        <= err_n;
            len_q        <= len_n;
            fwd_q        <= fwd_n;
            sos_q        <= sos_n;
            first_q      <= first_n;
            clr_q        <= clr_n;
            hdr_valid    <= hv_n;
            hdr_first    <= hf_n;
            hdr_data     <= hdat_n;
            hdr_tag      <= tag_n;
            scan_valid   <= sv_n;
            scan_data    <= sdat_n;
            scan_restart <= rs_n;
            scan_rst_num <= rnum_n;
            img_end      <= end_n;
        end
    end

    assign err_active = (st_q == S_ERR);
    assign err_code   = err_q;

endmodule

// File: rtl/jseg_parser.sv
// Top of the segment parser: serializer, classifier and walk. One clock,
// active-low asynchronous reset. No back-pressure from the output side;
// downstream must take every strobe as it comes.
module jseg_parser #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES*8-1:0] in_data,
    input  logic [LANES-1:0]   in_bvalid,
    output logic               in_ack,
    input  logic               scan_err,
    input  logic               clr_err,
    output logic               hdr_valid,
    output logic [7:0]         hdr_data,
    output logic [7:0]         hdr_tag,
    output logic               hdr_first,
    output logic               scan_valid,
    output logic [7:0]         scan_data,
    output logic               scan_restart,
    output logic [2:0]         scan_rst_num,
    output logic               img_end,
    output logic [2:0]         err_code
);
    import jsp_pkg::*;

    logic       byte_vld, err_active;
    logic [7:0] byte_dat;
    mclass_e    mclass;

    jsp_unpack #(.LANES(LANES)) u_unpack (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (err_active),
        .in_data  (in_data),
        .in_bvalid(in_bvalid),
        .in_ack   (in_ack),
        .byte_vld (byte_vld),
        .byte_dat (byte_dat)
    );

    jsp_classify u_class (
        .code  (byte_dat),
        .mclass(mclass)
    );

    jsp_walk u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld    (byte_vld),
        .byte_dat    (byte_dat),
        .mclass      (mclass),
        .scan_err    (scan_err),
        .clr_err     (clr_err),
        .err_active  (err_active),
        .err_code    (err_code),
        .hdr_valid   (hdr_valid),
        .hdr_data    (hdr_data),
        .hdr_tag     (hdr_tag),
        .hdr_first   (hdr_first),
        .scan_valid  (scan_valid),
        .scan_data   (scan_data),
        .scan_restart(scan_restart),
        .scan_rst_num(scan_rst_num),
        .img_end     (img_end)
    );

endmodule

// File: rtl/jseg_parser_chk.sv
// Protocol checker for the segment parser, bound to the top module.
// Observes ports only.
module jseg_parser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ack,
    input logic       clr_err,
    input logic       hdr_valid,
    input logic       hdr_first,
    input logic       scan_valid,
    input logic       scan_restart,
    input logic       img_end,
    input logic [2:0] err_code
);
    assert_ack_blocked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |-> !in_ack);

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7}));

    assert_first_in_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_first |-> hdr_valid);

    assert_one_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_valid, scan_valid, scan_restart, img_end}));

    assert_restart_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_restart |=> !scan_restart);

    assert_silent_in_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 3'd0) |-> !(hdr_valid || scan_valid || scan_restart || img_end));

    assert_hold_while_clr_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_code != 3'd0) && clr_err) |=> (err_code == $past(err_code)));

endmodule

bind jseg_parser jseg_parser_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ack      (in_ack),
    .clr_err     (clr_err),
    .hdr_valid   (hdr_valid),
    .hdr_first   (hdr_first),
    .scan_valid  (scan_valid),
    .scan_restart(scan_restart),
    .img_end     (img_end),
    .err_code    (err_code)
);

// File: tb/sim_jseg_parser.sv
// Scoreboard bench: stream builders push expected output events into a
// queue; a falling-edge monitor pops and compares every event produced.
module sim_jseg_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_bvalid = '0;
    logic        scan_err = 1'b0;
    logic        clr_err = 1'b0;
    logic        in_ack, hdr_valid, hdr_first, scan_valid, scan_restart, img_end;
    logic [7:0]  hdr_data, hdr_tag, scan_data;
    logic [2:0]  scan_rst_num, err_code;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0]  stream [$];
    logic [19:0] exq [$];
    string       exr [$];
    logic [19:0] got, want;
    string       req;

    always #5 clk = ~clk;

    jseg_parser u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_bvalid(in_bvalid),
        .in_ack(in_ack), .scan_err(scan_err), .clr_err(clr_err),
        .hdr_valid(hdr_valid), .hdr_data(hdr_data), .hdr_tag(hdr_tag),
        .hdr_first(hdr_first), .scan_valid(scan_valid), .scan_data(scan_data),
        .scan_restart(scan_restart), .scan_rst_num(scan_rst_num),
        .img_end(img_end), .err_code(err_code)
    );

    task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    endtask

    // Expected-event builders: {kind, first, tag, data}
    task automatic exp_ev(logic [2:0] k, logic f, logic [7:0] t, logic [7:0] d, string r);
        exq.push_back({k, f, t, d});
        exr.push_back(r);
    endtask

    task automatic pb(logic [7:0] b);
        stream.push_back(b);
    endtask

    // Segment with n body bytes base+i; forwarded ones are expected on hdr port
    task automatic seg(logic [7:0] code, int n, logic [7:0] base, bit fwd, string r);
        int len = n + 2;
        pb(8'hFF); pb(code); pb(8'(len >> 8)); pb(8'(len));
        for (int i = 0; i < n; i++) begin
            pb(base + 8'(i));
            if (fwd) exp_ev(3'd1, (i == 0), code, base + 8'(i), r);
        end
    endtask

    task automatic scan_b(logic [7:0] b, string r);
        pb(b);
        exp_ev(3'd2, 1'b0, 8'h00, b, r);
    endtask

    // Drive the byte stream as words; abort if the block enters error
    task automatic send();
        int i = 0;
        @(negedge clk);
        while (i < stream.size()) begin
            int n = (stream.size() - i > 4) ? 4 : stream.size() - i;
            logic [31:0] w = '0;
            bit abort = 0;
            for (int k = 0; k < n; k++) w[k*8 +: 8] = stream[i+k];
            in_data   = w;
            in_bvalid = 4'((1 << n) - 1);
            while (!in_ack) begin
                if (err_code != 3'd0) begin
                    abort = 1;
                    break;
                end
                @(negedge clk);
            end
            if (abort) break;
            @(negedge clk);
            i += n;
        end
        in_bvalid = '0;
        stream.delete();
        repeat (8) @(negedge clk);
    endtask

    task automatic drained(string r);
        chk(exq.size() == 0, r, exq.size(), 0);
        exq.delete();
        exr.delete();
    endtask

    // Check a latched code, its hold under clr_err, and the release
    task automatic clear_err(logic [2:0] code, string r);
        chk(err_code == code, r, err_code, code);
        chk(in_ack == 1'b0, "R1 ack low in error", in_ack, 0);
        clr_err = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(err_code == code, "R13 hold while clear high", err_code, code);
        clr_err = 1'b0;
        @(negedge clk);
        chk(err_code == 3'd0, "R13 released after clear low", err_code, 0);
        chk(in_ack == 1'b1, "R13 ack back after clear", in_ack, 1);
    endtask

    // Monitor: compare each output event against the queue head
    always @(negedge clk) begin
        if (rst_n && (hdr_valid || scan_valid || scan_restart || img_end)) begin
            if (hdr_valid)       got = {3'd1, hdr_first, hdr_tag, hdr_data};
            else if (scan_valid) got = {3'd2, 1'b0, 8'h00, scan_data};
            else if (scan_restart) got = {3'd3, 1'b0, 8'h00, 5'd0, scan_rst_num};
            else                 got = {3'd4, 1'b0, 8'h00, 8'h00};
            if (exq.size() == 0) begin
                chk(1'b0, "R2 no event expected", 32'(got), 0);
            end else begin
                want = exq.pop_front();
                req  = exr.pop_front();
                chk(got == want, req, 32'(got), 32'(want));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R14: reset state
        repeat (3) @(negedge clk);
        chk(err_code == 3'd0, "R14 reset err_code", err_code, 0);
        chk(!hdr_valid && !scan_valid && !scan_restart && !img_end, "R14 reset outputs", 0, 0);
        chk(in_ack == 1'b1, "R14 reset ack", in_ack, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: scan_err while hunting has no effect
        scan_err = 1'b1;
        @(negedge clk);
        scan_err = 1'b0;
        @(negedge clk);
        chk(err_code == 3'd0, "R11 scan_err ignored outside scan", err_code, 0);

        // Main image: junk, skip, fill, forward, stuffing, restarts, end
        pb(8'hFF); pb(8'h11); pb(8'hDA); pb(8'hFF); pb(8'hC0);   // R2 junk
        pb(8'hFF); pb(8'hD8);
        seg(8'hE1, 2, 8'h50, 0, "R4");
        pb(8'hFF); pb(8'hFF);                                     // R5 fill
        seg(8'hDB, 3, 8'h10, 1, "R3 DB");
        seg(8'hC0, 2, 8'h20, 1, "R3 C0");
        seg(8'hFE, 3, 8'h60, 0, "R4");
        seg(8'hDA, 1, 8'h30, 1, "R3 DA");
        scan_b(8'h12, "R6"); scan_b(8'h34, "R6");
        pb(8'hFF); pb(8'h00); exp_ev(3'd2, 1'b0, 8'h00, 8'hFF, "R6 unstuff");
        scan_b(8'h56, "R6");
        pb(8'hFF); pb(8'hFF); pb(8'hD3); exp_ev(3'd3, 1'b0, 8'h00, 8'h03, "R7 R5");
        scan_b(8'h78, "R6");
        pb(8'hFF); pb(8'hD5); exp_ev(3'd3, 1'b0, 8'h00, 8'h05, "R7");
        scan_b(8'h9A, "R6");
        pb(8'hFF); pb(8'hD9); exp_ev(3'd4, 1'b0, 8'h00, 8'h00, "R8");
        if (stream.size() % 4 == 0) stream.push_front(8'h00);    // R1 partial word
        send();
        drained("R1 R8 main image");
        chk(err_code == 3'd0, "R7 no error", err_code, 0);

        // Reordered headers, restart interval, backwards restart numbers
        pb(8'hFF); pb(8'hD8);
        seg(8'hDD, 2, 8'h05, 1, "R3 DD");
        seg(8'hC4, 4, 8'hA0, 1, "R3 C4");
        seg(8'hE5, 1, 8'h77, 0, "R4");
        seg(8'hC0, 1, 8'hB0, 1, "R3 C0");
        seg(8'hDB, 2, 8'hC0, 1, "R3 DB");
        seg(8'hDA, 2, 8'hD0, 1, "R3 DA");
        scan_b(8'h01, "R6");
        pb(8'hFF); pb(8'hD7); exp_ev(3'd3, 1'b0, 8'h00, 8'h07, "R7");
        scan_b(8'h02, "R6");
        pb(8'hFF); pb(8'hD0); exp_ev(3'd3, 1'b0, 8'h00, 8'h00, "R7");
        pb(8'hFF); pb(8'hD9); exp_ev(3'd4, 1'b0, 8'h00, 8'h00, "R8");
        send();
        drained("R3 reordered");
        chk(err_code == 3'd0, "R7 order not checked", err_code, 0);

        // End-of-image before start-of-scan
        pb(8'hFF); pb(8'hD8);
        seg(8'hDB, 1, 8'h44, 1, "R3");
        pb(8'hFF); pb(8'hD9);
        send();
        drained("R10");
        clear_err(3'd3, "R10 EOI before SOS");

        // Invalid and unsupported codes
        pb(8'hFF); pb(8'hD8); pb(8'hFF); pb(8'h42);
        send();
        clear_err(3'd1, "R9 invalid code");
        pb(8'hFF); pb(8'hD8); pb(8'hFF); pb(8'hC2);
        send();
        clear_err(3'd2, "R9 unsupported C2");
        pb(8'hFF); pb(8'hD8); pb(8'hFF); pb(8'hF3);
        send();
        clear_err(3'd2, "R9 unsupported F3");

        // Unexpected defined marker inside scan data
        pb(8'hFF); pb(8'hD8);
        seg(8'hDA, 1, 8'h31, 1, "R3");
        scan_b(8'h5A, "R6");
        pb(8'hFF); pb(8'hC4);
        send();
        drained("R10");
        clear_err(3'd3, "R10 marker in scan");

        // Length below two, and a non-FF byte where a marker is due
        pb(8'hFF); pb(8'hD8); pb(8'hFF); pb(8'hDB); pb(8'h00); pb(8'h01);
        send();
        clear_err(3'd7, "R12 short length");
        pb(8'hFF); pb(8'hD8); pb(8'h55);
        send();
        clear_err(3'd7, "R12 missing FF");

        // Downstream scan fault while in scan data
        pb(8'hFF); pb(8'hD8);
        seg(8'hDA, 1, 8'h32, 1, "R3");
        scan_b(8'h66, "R6");
        send();
        drained("R6");
        scan_err = 1'b1;
        @(negedge clk);
        scan_err = 1'b0;
        chk(err_code == 3'd4, "R11 scan fault", err_code, 4);
        @(negedge clk);
        clear_err(3'd4, "R11 scan fault");

        // After clear: marker-like junk discarded until start-of-image
        pb(8'h12); pb(8'hFF); pb(8'hDA); pb(8'h00); pb(8'h03); pb(8'h44);
        pb(8'hFF); pb(8'h42); pb(8'hFF); pb(8'hFF); pb(8'hD8);
        seg(8'hC0, 1, 8'hE0, 1, "R13 R2 hunt");
        seg(8'hDA, 0, 8'h00, 1, "R3");
        scan_b(8'h21, "R13 R2 hunt");
        pb(8'hFF); pb(8'hD9); exp_ev(3'd4, 1'b0, 8'h00, 8'h00, "R8");
        send();
        drained("R2 hunt after clear");
        chk(err_code == 3'd0, "R2 junk raises nothing", err_code, 0);

        // Asynchronous reset out of an error state
        pb(8'hFF); pb(8'hD8); pb(8'hFF); pb(8'h42);
        send();
        chk(err_code == 3'd1, "R9 invalid before reset", err_code, 1);
        #2 rst_n = 1'b0;
        #1 chk(err_code == 3'd0, "R14 async clear", err_code, 0);
        chk(in_ack == 1'b1, "R14 async ack", in_ack, 1);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule